// File: doc/BRIEF.md
# Timer Clock-Select Prescaler

This block turns a 3-bit clock-select code into a one-cycle count-enable tick for a timer. The tick lives entirely in the system clock domain. The timer counter samples it as a plain enable, and no derived clock is ever built. The code can hold the timer still, let it advance on every clock, slow it down through a shared free-running prescaler, or make it follow an external pin.

The prescaler is a 10-bit counter that starts at zero when reset is released and runs freely afterwards. A code change never clears it. The four divide codes use its low 3, 6, 8 and 10 bits. The external pin passes through a two-flop synchronizer. Its edges are found by comparing the synchronized value with the previous synchronized sample. One code selects falling edges and another selects rising edges.

The output tick is registered. A new code applies from the next rising clock edge.

Top module: `tps_clock_select`

## Requirements
- R1: While the synchronous, active-high reset is sampled high, the tick is low after that edge. Reset also clears the prescaler to zero and clears both synchronizer flops and the previous-sample flop to 0.
- R2: With code 3'b000 the tick stays low, whatever the external pin does.
- R3: With code 3'b001 the tick is high in every cycle that follows a clock edge at which the code was 3'b001.
- R4: Let P be the prescaler value before an edge, that is, the number of edges since reset release modulo 1024. Codes 3'b010, 3'b011, 3'b100 and 3'b101 raise the tick after that edge exactly when the low 3, 6, 8 or 10 bits of P are all ones. This gives one tick per 8, 64, 256 or 1024 cycles, and the pin has no effect.
- R5: With code 3'b110, a high-to-low change of the pin raises the tick for one cycle. The tick appears after the third rising clock edge that samples the new pin level (two synchronizer stages plus the output register).
- R6: With code 3'b111, a low-to-high change of the pin raises the tick for one cycle, with the same three-edge latency as R5.
- R7: The tick is never high in two consecutive cycles under a divide or edge code. A change of code takes effect at the next edge and does not restart the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sel_i | input | 3 | Clock-select code |
| ext_pin_i | input | 1 | External count pin, asynchronous |
| tick_o | output | 1 | One-cycle count enable |

## Verification
Each code is held while the pin toggles with irregular spacing. This shows that the stop and divide codes really ignore the pin and that the edge codes respond only to their own edge polarity. The divide codes are also observed over windows of exact multiples of the division ratio. A wrong tap shows up as a wrong tick count there, not only as a wrong phase. Codes are also switched in mid-run without any reset. A prescaler that restarted on a code change would then put its ticks in the wrong cycles.

// File: rtl/tps_pkg.sv
package tps_pkg;
   typedef enum logic [2:0] {
      CS_STOP     = 3'b000,
      CS_PASS     = 3'b001,
      CS_DIV_A    = 3'b010,
      CS_DIV_B    = 3'b011,
      CS_DIV_C    = 3'b100,
      CS_DIV_D    = 3'b101,
      CS_EXT_FALL = 3'b110,
      CS_EXT_RISE = 3'b111
   } clk_sel_e;

   localparam int SEL_W    = 3;
   localparam int NUM_TAPS = 4;
endpackage

// File: rtl/tps_prescaler.sv
module tps_prescaler #(
   parameter int CNT_W    = 10,
   parameter int TAP0_LOG = 3,
   parameter int TAP1_LOG = 6,
   parameter int TAP2_LOG = 8,
   parameter int TAP3_LOG = 10
) (
   input  logic                         clk_i,
   input  logic                         rst_i,
   output logic [tps_pkg::NUM_TAPS-1:0] tap_hit_o
);
   localparam int TapLog [tps_pkg::NUM_TAPS] = '{TAP0_LOG, TAP1_LOG, TAP2_LOG, TAP3_LOG};

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_w
         $error("tps_prescaler: CNT_W must be positive");
      end
      if (TAP3_LOG > CNT_W) begin : g_bad_top
         $error("tps_prescaler: widest tap exceeds counter width");
      end
      if (!(TAP0_LOG >= 1 && TAP0_LOG < TAP1_LOG && TAP1_LOG < TAP2_LOG && TAP2_LOG < TAP3_LOG)) begin : g_bad_order
         $error("tps_prescaler: taps must be positive and strictly increasing");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < tps_pkg::NUM_TAPS; i++) begin : g_tap
      assign tap_hit_o[i] = &cnt_q[TapLog[i]-1:0];
   end
endmodule

// File: rtl/tps_pin_sync.sv
module tps_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;
   logic              synced;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tps_pin_sync: at least two synchronizer stages required");
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i) chain_q <= '0;
      else       chain_q <= {chain_q[STAGES-2:0], pin_i};
   end

   assign synced = chain_q[STAGES-1];

   always_ff @(posedge clk_i) begin
      if (rst_i) prev_q <= 1'b0;
      else       prev_q <= synced;
   end

   assign rise_o = synced & ~prev_q;
   assign fall_o = ~synced & prev_q;
endmodule

// File: rtl/tps_tick_select.sv
module tps_tick_select
   import tps_pkg::*;
(
   input  logic                clk_i,
   input  logic                rst_i,
   input  logic [SEL_W-1:0]    sel_i,
   input  logic [NUM_TAPS-1:0] tap_hit_i,
   input  logic                rise_i,
   input  logic                fall_i,
   output logic                tick_o
);
   logic tick_d;
   clk_sel_e sel;

   assign sel = clk_sel_e'(sel_i);

   always_comb begin
      unique case (sel)
         CS_STOP:     tick_d = 1'b0;
         CS_PASS:     tick_d = 1'b1;
         CS_DIV_A:    tick_d = tap_hit_i[0];
         CS_DIV_B:    tick_d = tap_hit_i[1];
         CS_DIV_C:    tick_d = tap_hit_i[2];
         CS_DIV_D:    tick_d = tap_hit_i[3];
         CS_EXT_FALL: tick_d = fall_i;
         CS_EXT_RISE: tick_d = rise_i;
         default:     tick_d = 1'b0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) tick_o <= 1'b0;
      else       tick_o <= tick_d;
   end
endmodule

// File: rtl/tps_clock_select.sv
module tps_clock_select #(
   parameter int CNT_W       = 10,
   parameter int TAP0_LOG    = 3,
   parameter int TAP1_LOG    = 6,
   parameter int TAP2_LOG    = 8,
   parameter int TAP3_LOG    = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic [2:0] sel_i,
   input  logic       ext_pin_i,
   output logic       tick_o
);
   logic [tps_pkg::NUM_TAPS-1:0] tap_hit;
   logic                         pin_rise;
   logic                         pin_fall;

   tps_prescaler #(
      .CNT_W   (CNT_W),
      .TAP0_LOG(TAP0_LOG),
      .TAP1_LOG(TAP1_LOG),
      .TAP2_LOG(TAP2_LOG),
      .TAP3_LOG(TAP3_LOG)
   ) u_presc (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .tap_hit_o(tap_hit)
   );

   tps_pin_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .pin_i (ext_pin_i),
      .rise_o(pin_rise),
      .fall_o(pin_fall)
   );

   tps_tick_select u_sel (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .sel_i    (sel_i),
      .tap_hit_i(tap_hit),
      .rise_i   (pin_rise),
      .fall_i   (pin_fall),
      .tick_o   (tick_o)
   );
endmodule

// File: rtl/tps_clock_select_chk.sv
module tps_clock_select_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic [2:0] sel_i,
   input logic       tick_o
);
   AST_RESET_QUIET: assert property (@(posedge clk_i) rst_i |=> !tick_o); // R1

   AST_STOP_NO_TICK: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i == 3'b000) |=> !tick_o); // R2

   AST_PASS_EVERY: assert property (@(posedge clk_i) disable iff (rst_i)
      (sel_i == 3'b001) |=> tick_o); // R3

   AST_DIV8_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && sel_i == 3'b010) |=> (sel_i != 3'b010 || !tick_o)); // R4

   AST_FALL_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && sel_i == 3'b110) |=> (sel_i != 3'b110 || !tick_o)); // R5

   AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && sel_i == 3'b111) |=> (sel_i != 3'b111 || !tick_o)); // R6

   AST_DIV1024_GAP: assert property (@(posedge clk_i) disable iff (rst_i)
      (tick_o && sel_i == 3'b101) |=> (sel_i != 3'b101 || !tick_o)); // R7
endmodule

bind tps_clock_select tps_clock_select_chk u_chk (
   .clk_i (clk_i),
   .rst_i (rst_i),
   .sel_i (sel_i),
   .tick_o(tick_o)
);

// File: tb/tps_clock_select_tb.sv
module tps_clock_select_tb;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] sel = 3'b000;
   logic       pin = 1'b0;
   logic       tick;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   tps_clock_select u_dut (
      .clk_i    (clk),
      .rst_i    (rst),
      .sel_i    (sel),
      .ext_pin_i(pin),
      .tick_o   (tick)
   );

   // behavioural reference
   int   m_cnt;
   bit   m_hist[$];
   bit   m_exp;
   string m_tag;
   logic [2:0] m_last_sel;

   function automatic string req_of(logic [2:0] s);
      case (s)
         3'b000:  return "R2";
         3'b001:  return "R3";
         3'b110:  return "R5";
         3'b111:  return "R6";
         default: return "R4";
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         m_cnt = 0;
         m_hist = {1'b0, 1'b0, 1'b0};
         m_exp = 1'b0;
         m_tag = "R1";
      end else begin
         bit s2, pv;
         s2 = m_hist[1];
         pv = m_hist[2];
         case (sel)
            3'b000: m_exp = 1'b0;
            3'b001: m_exp = 1'b1;
            3'b010: m_exp = (m_cnt % 8)    == 7;
            3'b011: m_exp = (m_cnt % 64)   == 63;
            3'b100: m_exp = (m_cnt % 256)  == 255;
            3'b101: m_exp = (m_cnt % 1024) == 1023;
            3'b110: m_exp = pv && !s2;
            default: m_exp = !pv && s2;
         endcase
         m_tag = (sel != m_last_sel) ? "R7" : req_of(sel);
         m_hist.push_front(pin);
         void'(m_hist.pop_back());
         m_cnt = (m_cnt + 1) % 1024;
      end
      m_last_sel = sel;
   end

   always @(negedge clk) begin
      if (!done) begin
         n_checks++;
         if (tick !== m_exp) begin
            n_fail++;
            $display("FAIL %s: tick actual %b expected %b at %0t", m_tag, tick, m_exp, $time);
         end
      end
   end

   task automatic run(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic count_window(int n, int want, string req);
      int got = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (tick === 1'b1) got++;
      end
      n_checks++;
      if (got != want) begin
         n_fail++;
         $display("FAIL %s: tick count actual %0d expected %0d", req, got, want);
      end
   endtask

   task automatic pulses(int n, int hi, int lo);
      for (int i = 0; i < n; i++) begin
         pin = 1'b1; run(hi);
         pin = 1'b0; run(lo);
      end
   endtask

   initial begin
      run(4);
      rst = 1'b0;
      // R2: stopped while pin toggles
      sel = 3'b000; pulses(6, 3, 5);
      // R3: every cycle
      sel = 3'b001; run(2);
      count_window(40, 40, "R3");
      // R4: dividers with pin noise; exact-multiple windows
      sel = 3'b010; pin = 1'b1; run(1);
      count_window(80, 10, "R4");
      sel = 3'b011; pulses(4, 2, 7); run(1);
      count_window(256, 4, "R4");
      sel = 3'b100; run(1);
      count_window(1024, 4, "R4");
      sel = 3'b101; pulses(3, 4, 4); run(1);
      count_window(2048, 2, "R4");
      // R5 falling edges, irregular spacing
      pin = 1'b0; sel = 3'b110; run(6);
      pulses(1, 5, 6); pulses(1, 1, 9); pulses(1, 8, 3);
      run(6);
      sel = 3'b110; pin = 1'b0; run(4);
      count_window(0, 0, "R5");
      begin
         int got = 0;
         fork
            begin pulses(5, 4, 5); run(6); end
            begin
               for (int i = 0; i < 51; i++) begin
                  @(negedge clk);
                  if (tick === 1'b1) got++;
               end
            end
         join
         n_checks++;
         if (got != 5) begin n_fail++; $display("FAIL R5: falling count actual %0d expected %0d", got, 5); end
      end
      // R6 rising edges
      sel = 3'b111; run(4);
      begin
         int got = 0;
         fork
            begin pulses(4, 2, 6); run(6); end
            begin
               for (int i = 0; i < 38; i++) begin
                  @(negedge clk);
                  if (tick === 1'b1) got++;
               end
            end
         join
         n_checks++;
         if (got != 4) begin n_fail++; $display("FAIL R6: rising count actual %0d expected %0d", got, 4); end
      end
      // R7: rapid code switching without reset
      for (int k = 0; k < 24; k++) begin
         sel = 3'(k * 5 + 2);
         pin = k[0];
         run(3 + (k % 7));
      end
      sel = 3'b011; run(200);
      // R1: reset mid-run
      sel = 3'b001; rst = 1'b1; run(3);
      rst = 1'b0; sel = 3'b010; run(40);
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      #500000;
      n_checks++;
      n_fail++;
      done = 1'b1;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule